// File: doc/BRIEF.md
# Memory-Mapped Chip Select Decoder

This block turns the address and memory-request strobe of a small processor into one chip select per region of its address space. The top address bits pick one of four equal regions. Region 0 holds a read-only device. Regions 1 to 3 each hold a RAM. The block also carries behavioural models of those devices, so the read bus shows the data a real board would return: the ROM's fixed pattern, the RAM contents, all ones on an unmapped access, and the wired-AND result when two devices drive the bus together.

Each region has two configuration bits: present or empty, and full or partial decoding. These bits are captured while reset is held and stay frozen once reset is released. Under full decoding, each device byte answers at exactly one address. That address lies at the bottom of its region, and the rest of the region is unmapped. Under partial decoding, the region ignores the lower region-select bit and every address bit above the device's own offset. The device then repeats through half of the space. Two partially decoded devices may then claim the same address, and the block flags this as a bus conflict.

Top module: `memsel_decoder`

## Requirements
- R1: With a region present and fully decoded, an access with `mem_req` high selects `cs[i]` only when the two top address bits equal `i`. Region 0 is the ROM and regions 1, 2 and 3 are RAMs.
- R2: No bit of `cs` is high while `mem_req` is low, and a write strobe without `mem_req` stores nothing.
- R3: Under full decoding, a region is selected only when the address bits between the device offset (the low `DEV_AW` bits) and the region bits are all zero. Any other address in the region selects nothing and reads FFh.
- R4: Under partial decoding, region `i` is selected whenever the top address bit equals bit 1 of `i`. The low `DEV_AW` bits pick the byte, so each byte appears at every address that differs only in the ignored bits.
- R5: A region configured as empty is never selected, returns FFh on reads, and keeps no written data.
- R6: The ROM at offset `o` returns `((o mod 256) XOR ((o/256)*37 mod 256)) + 60` mod 256. A write to it changes nothing.
- R7: A RAM write commits on the rising clock edge while `wr_stb`, `mem_req` and that RAM's select are all high. A later read of any address that selects that RAM at the same offset returns the stored byte.
- R8: `conflict` is high exactly while more than one `cs` bit is high. The read data is then the bitwise AND of all selected devices. A write in such a cycle stores into every selected RAM.
- R9: `rdata` is FFh whenever `rd_stb` and `mem_req` are not both high. When they are both high, `rdata` is the selected data, or FFh if nothing is selected.
- R10: `cfg_present` and `cfg_partial` (bit `i` for region `i`) are sampled on clock edges while `rst_n` is low. Changes to them after reset is released have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; RAM writes and configuration capture |
| rst_n | input | 1 | Active-low synchronous reset; configuration is loaded while low |
| mem_req | input | 1 | Memory request strobe, active high |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| addr | input | ADDR_W (16) | Processor address |
| wdata | input | DATA_W (8) | Write data |
| cfg_present | input | 4 | Per-region present (1) or empty (0) |
| cfg_partial | input | 4 | Per-region partial (1) or full (0) decoding |
| cs | output | 4 | Chip selects, one per region, active high |
| rdata | output | DATA_W (8) | Read data bus |
| conflict | output | 1 | More than one chip select active |

## Verification
The bench builds the block with `DEV_AW` = 6, so each device holds 64 bytes and the other widths keep their defaults. At that size every RAM byte can be written with a known value, and the whole 64 KB address space can be read back under each configuration. The sweeps cover full decoding, mixed partial decoding with overlaps, an all-partial layout in which every address conflicts, and an all-empty layout. This reaches every alias, every unmapped gap and every conflicting pair, as well as the configuration inputs being changed after reset.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

  // Does region idx claim address a?  aw: address width, rw: region-select
  // width, dw: device offset width.  Partial decoding drops the lowest
  // region-select bit and the gap bits between the offset and the region.
  function automatic logic region_hit(input logic [31:0] a, input int unsigned idx,
                                      input logic partial, input int unsigned aw,
                                      input int unsigned rw, input int unsigned dw);
    logic [31:0] gap_mask;
    gap_mask = (32'd1 << (aw - rw - dw)) - 32'd1;
    if (partial)
      return (a >> (aw - rw + 1)) == 32'(idx >> 1);
    return ((a >> (aw - rw)) == 32'(idx)) && (((a >> dw) & gap_mask) == 32'd0);
  endfunction

  // Fixed ROM pattern as a function of the device offset.
  function automatic logic [31:0] rom_pattern(input logic [31:0] off);
    logic [31:0] lo, hi;
    lo = off & 32'hFF;
    hi = ((off >> 8) * 32'd37) & 32'hFF;
    return ((lo ^ hi) + 32'd60) & 32'hFF;
  endfunction

endpackage

// File: rtl/memsel_region_dec.sv
module memsel_region_dec
  import memsel_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int RSEL_W = 2,
  parameter int DEV_AW = 9,
  parameter int IDX    = 0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              present,
  input  logic              partial,
  output logic              hit
);
  always_comb
    hit = present && region_hit(32'(addr), IDX, partial, ADDR_W, RSEL_W, DEV_AW);
endmodule

// File: rtl/memsel_rom_model.sv
module memsel_rom_model
  import memsel_pkg::*;
#(
  parameter int DEV_AW = 9,
  parameter int DATA_W = 8
) (
  input  logic [DEV_AW-1:0] off,
  output logic [DATA_W-1:0] rdata
);
  logic [31:0] pattern;
  always_comb begin
    pattern = rom_pattern(32'(off));
    rdata   = pattern[DATA_W-1:0];
  end
endmodule

// File: rtl/memsel_ram_model.sv
module memsel_ram_model #(
  parameter int DEV_AW = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [DEV_AW-1:0] off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << DEV_AW;
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk)
    if (we) store[off] <= wdata;

  assign rdata = store[off];
endmodule

// File: rtl/memsel_bus_merge.sv
module memsel_bus_merge #(
  parameter int NREG   = 4,
  parameter int DATA_W = 8
) (
  input  logic [NREG-1:0]             sel,
  input  logic [NREG-1:0][DATA_W-1:0] drv,
  output logic [DATA_W-1:0]           merged,
  output logic                        multi
);
  localparam int CNT_W = $clog2(NREG + 1);
  logic [CNT_W-1:0] n_sel;

  always_comb begin
    merged = '1;
    n_sel  = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sel[i]) begin
        merged = merged & drv[i];
        n_sel  = n_sel + CNT_W'(1);
      end
    end
    multi = n_sel > CNT_W'(1);
  end
endmodule

// File: rtl/memsel_decoder.sv
module memsel_decoder #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RSEL_W = 2,
  parameter int DEV_AW = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mem_req,
  input  logic                     rd_stb,
  input  logic                     wr_stb,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [(1<<RSEL_W)-1:0]   cfg_present,
  input  logic [(1<<RSEL_W)-1:0]   cfg_partial,
  output logic [(1<<RSEL_W)-1:0]   cs,
  output logic [DATA_W-1:0]        rdata,
  output logic                     conflict
);
  localparam int NREG    = 1 << RSEL_W;
  localparam int ROM_IDX = 0;

  // Configuration captured while reset is held.
  logic [NREG-1:0] present_q, partial_q;
  always_ff @(posedge clk)
    if (!rst_n) begin
      present_q <= cfg_present;
      partial_q <= cfg_partial;
    end

  // Named internal events for the checker.
  logic [NREG-1:0]             hit_raw;
  logic [NREG-1:0]             sel;
  logic [NREG-1:0]             ram_we;
  logic [NREG-1:0][DATA_W-1:0] drv;
  logic [DATA_W-1:0]           merged;
  logic                        multi;
  logic [DEV_AW-1:0]           dev_off;

  assign dev_off = addr[DEV_AW-1:0];
  assign sel     = hit_raw & {NREG{mem_req}};

  for (genvar r = 0; r < NREG; r++) begin : g_region
    memsel_region_dec #(
      .ADDR_W(ADDR_W), .RSEL_W(RSEL_W), .DEV_AW(DEV_AW), .IDX(r)
    ) u_dec (
      .addr(addr), .present(present_q[r]), .partial(partial_q[r]), .hit(hit_raw[r])
    );
    if (r == ROM_IDX) begin : g_rom
      assign ram_we[r] = 1'b0;
      memsel_rom_model #(.DEV_AW(DEV_AW), .DATA_W(DATA_W)) u_rom (
        .off(dev_off), .rdata(drv[r])
      );
    end else begin : g_ram
      assign ram_we[r] = sel[r] & wr_stb;
      memsel_ram_model #(.DEV_AW(DEV_AW), .DATA_W(DATA_W)) u_ram (
        .clk(clk), .we(ram_we[r]), .off(dev_off), .wdata(wdata), .rdata(drv[r])
      );
    end
  end

  memsel_bus_merge #(.NREG(NREG), .DATA_W(DATA_W)) u_merge (
    .sel(sel), .drv(drv), .merged(merged), .multi(multi)
  );

  assign cs       = sel;
  assign conflict = multi;
  assign rdata    = (mem_req && rd_stb) ? merged : '1;
endmodule

// File: rtl/memsel_decoder_chk.sv
module memsel_decoder_chk #(
  parameter int NREG   = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              rd_stb,
  input logic [NREG-1:0]   cs,
  input logic [DATA_W-1:0] rdata,
  input logic              conflict,
  input logic [NREG-1:0]   present_q,
  input logic [NREG-1:0]   partial_q,
  input logic [NREG-1:0]   hit_raw
);
  a_r2_no_cs_without_req: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> (cs == '0));

  a_r2_cs_within_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (cs & ~hit_raw) == '0);

  a_r5_empty_never_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (cs & ~present_q) == '0);

  a_r3_full_decode_single: assert property (@(posedge clk) disable iff (!rst_n)
    (partial_q == '0) |-> $onehot0(cs));

  a_r8_conflict_on_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cs) > 1) |-> conflict);

  a_r8_no_false_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cs) <= 1) |-> !conflict);

  a_r9_idle_bus_high: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && rd_stb) |-> (rdata == '1));

  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(present_q) && $stable(partial_q)));
endmodule

bind memsel_decoder memsel_decoder_chk #(.NREG(NREG), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .rd_stb(rd_stb), .cs(cs),
  .rdata(rdata), .conflict(conflict), .present_q(present_q),
  .partial_q(partial_q), .hit_raw(hit_raw)
);

// File: tb/memsel_decoder_test.sv
`timescale 1ns/1ps
module memsel_decoder_test;
  localparam int BDEV = 6;
  localparam int BSZ  = 1 << BDEV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [3:0]  cfg_present = 4'hF, cfg_partial = 4'h0;
  logic [3:0]  cs;
  logic [7:0]  rdata;
  logic        conflict;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [3:0] cur_p, cur_q;
  logic [7:0] mirror [4][BSZ];

  memsel_decoder #(.DEV_AW(BDEV)) uut (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .addr(addr), .wdata(wdata), .cfg_present(cfg_present), .cfg_partial(cfg_partial),
    .cs(cs), .rdata(rdata), .conflict(conflict)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%h: actual=%h expected=%h", req, addr, got, exp);
    end
  endtask

  function automatic logic hits(input logic [15:0] a, input int r);
    logic [1:0] rr;
    rr = 2'(r);
    if (!cur_p[r]) return 1'b0;
    if (cur_q[r]) return a[15] == rr[1];
    return (a[15:14] == rr) && (a[13:BDEV] == '0);
  endfunction

  function automatic logic [7:0] rom_exp(input int off);
    return 8'((((off & 255) ^ (((off >> 8) * 37) & 255)) + 60) & 255);
  endfunction

  // {cs, conflict, rdata}
  function automatic logic [12:0] expect_bus(input logic [15:0] a, input logic req, input logic rd);
    logic [3:0] c;
    logic [7:0] d;
    int n;
    int off;
    c = '0; d = 8'hFF; n = 0; off = int'(a) % BSZ;
    for (int r = 0; r < 4; r++) begin
      if (req && hits(a, r)) begin
        c[r] = 1'b1; n++;
        d = d & ((r == 0) ? rom_exp(off) : mirror[r][off]);
      end
    end
    if (!(req && rd)) d = 8'hFF;
    return {c, (n > 1), d};
  endfunction

  task automatic do_write(input logic [15:0] a, input logic [7:0] v, input logic req);
    @(negedge clk);
    addr = a; wdata = v; mem_req = req; rd_stb = 1'b0; wr_stb = 1'b1;
    for (int r = 1; r < 4; r++)
      if (req && hits(a, r)) mirror[r][int'(a) % BSZ] = v;
    @(negedge clk);
    wr_stb = 1'b0; mem_req = 1'b0;
  endtask

  task automatic apply_cfg(input logic [3:0] p, input logic [3:0] q);
    @(negedge clk);
    rst_n = 1'b0; mem_req = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0;
    cfg_present = p; cfg_partial = q;
    repeat (3) @(negedge clk);
    // R2/R9 reset state: idle bus, no selects, no conflict
    chk("R2 R9 reset state", {19'd0, cs, conflict, rdata}, {19'd0, 4'h0, 1'b0, 8'hFF});
    rst_n = 1'b1;
    cur_p = p; cur_q = q;
    @(negedge clk);
    // R10: later changes to the configuration inputs must not matter
    cfg_present = ~p; cfg_partial = ~q;
  endtask

  task automatic sweep(input string req);
    @(negedge clk);
    mem_req = 1'b1; rd_stb = 1'b1; wr_stb = 1'b0;
    for (int a = 0; a < 65536; a++) begin
      addr = 16'(a);
      #1;
      chk(req, {19'd0, cs, conflict, rdata}, {19'd0, expect_bus(16'(a), 1'b1, 1'b1)});
    end
    // R9 and R2: strobes not both active
    for (int a = 0; a < 65536; a += 4099) begin
      addr = 16'(a);
      mem_req = 1'b1; rd_stb = 1'b0; #1;
      chk("R9 no read strobe", {19'd0, cs, conflict, rdata},
          {19'd0, expect_bus(16'(a), 1'b1, 1'b0)});
      mem_req = 1'b0; rd_stb = 1'b1; #1;
      chk("R2 R9 no request", {19'd0, cs, conflict, rdata}, {19'd0, 4'h0, 1'b0, 8'hFF});
    end
    mem_req = 1'b0; rd_stb = 1'b0;
  endtask

  initial begin
    // Config A: all present, full decode.
    apply_cfg(4'b1111, 4'b0000);
    for (int r = 1; r < 4; r++)
      for (int o = 0; o < BSZ; o++)
        do_write(16'((r << 14) | o), 8'((r * 53 + o * 7) & 255), 1'b1);
    for (int o = 0; o < BSZ; o += 3)
      do_write(16'(o), 8'h00, 1'b1);                 // R6 ROM write ignored
    do_write(16'h4005, 8'hEE, 1'b0);                 // R2 write without request
    do_write(16'h4000 | 16'(BSZ) | 16'h5, 8'hDD, 1'b1); // R3 gap address, unselected
    sweep("R1 R3 R6 R7 full map");

    // Config B: region 2 empty, regions 0 and 3 partial -> overlaps.
    apply_cfg(4'b1011, 4'b1001);
    for (int o = 0; o < BSZ; o++)
      do_write(16'h4000 | 16'(o), 8'((o * 3 + 11) & 255), 1'b1); // R8 write in conflict
    for (int o = 0; o < BSZ; o += 2)
      do_write(16'h9000 | 16'(o), 8'((o * 5 + 1) & 255), 1'b1);  // R4 alias write
    do_write(16'h5040, 8'h77, 1'b1);
    sweep("R4 R5 R7 R8 R10 partial map");

    // Config C: everything partial, every address conflicts.
    apply_cfg(4'b1111, 4'b1111);
    for (int o = 0; o < BSZ; o += 5)
      do_write(16'hC000 | 16'(o), 8'((o * 9 + 2) & 255), 1'b1);
    sweep("R4 R8 all overlapping");

    // Config D: all empty; writes must be dropped.
    apply_cfg(4'b0000, 4'b0000);
    for (int o = 0; o < BSZ; o += 4) begin
      do_write(16'h4000 | 16'(o), 8'h11, 1'b1);
      do_write(16'hC000 | 16'(o), 8'h22, 1'b1);
    end
    sweep("R5 all empty");

    // Config E: back to full decode, confirms config D stored nothing.
    apply_cfg(4'b1111, 4'b0000);
    sweep("R5 R7 contents after empty phase");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule